// File: doc/BRIEF.md
# Snoop Result Combiner and Memory Responder

This block sits on the memory side of a snooping shared bus. When a bus transaction is accepted, it merges the per-cache snoop outputs into three wired-OR lines. The first line means some cache holds a copy, the second means some cache holds a modified copy, and the third means a snoop is still in progress. Main memory stays silent until the snoop outcome is known. Once the outcome is known, the block either returns the word from its small internal register file, or stays silent and lets the owning cache supply the data. When it stays silent it also captures that flushed word, so memory becomes up to date.

The snoop window can end in one of two ways, chosen by a parameter. In variable mode it lasts until the combined in-progress line is low at a clock edge. In fixed mode it lasts a set number of cycles and the in-progress line is not looked at. The block handles one transaction at a time. When the transaction finishes, it raises a one-cycle completion strobe and returns the combined copy-held bit with it, so the requester can pick a clean-exclusive or a shared fill.

Top module: `snoop_mem_responder`

## Requirements
- R1: `sum_shared`, `sum_dirty` and `sum_inhibit` are the OR of all bits of `snp_shared`, `snp_dirty` and `snp_inhibit` respectively, in the same cycle.
- R2: With `FIXED_LAT`=0, the snoop window ends at the first clock edge after acceptance at which `sum_inhibit` is low. `done` is high in the cycle after that edge. If the in-progress line stays high for k edges after the accept edge, `done` is seen k+1 cycles after the accept edge.
- R3: With `FIXED_LAT`=1, `done` is high exactly `SNOOP_LAT` cycles after the accept edge, whatever `snp_inhibit` does.
- R4: For a read (`req_cmd`=2'b00) or read-exclusive (2'b01) where `sum_dirty` is low at window end, `mem_resp_valid` is high together with `done`, and `mem_resp_data` equals the stored word at `req_addr`. Whenever `mem_resp_valid` is low, `mem_resp_data` is zero.
- R5: For a read or read-exclusive where `sum_dirty` is high at window end, memory gives no response. At that edge it stores `flush_data` at the address.
- R6: `done` is high for exactly one cycle per transaction. `done_shared` equals `sum_shared` as it was at the window-ending edge, and is low when `done` is low.
- R7: For a write-back (`req_cmd`=2'b11), the word captured from `req_wdata` at acceptance is stored at window end, and there is no response.
- R8: For an upgrade (`req_cmd`=2'b10), `done` is raised with no response, and memory is unchanged.
- R9: Only one transaction is active at a time. `req_valid` is ignored from the accept edge until the edge after `done`.
- R10: After reset the block is idle, with `done` and `mem_resp_valid` low, and every stored word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus transaction present |
| req_cmd | input | 2 | 00 read, 01 read-exclusive, 10 upgrade, 11 write-back |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write-back data |
| snp_shared | input | N_CACHE | Per-cache "holds a copy" |
| snp_dirty | input | N_CACHE | Per-cache "holds a modified copy" |
| snp_inhibit | input | N_CACHE | Per-cache "snoop not finished" |
| flush_data | input | DATA_W | Data driven by the owning cache |
| sum_shared | output | 1 | Combined copy-held line |
| sum_dirty | output | 1 | Combined modified line |
| sum_inhibit | output | 1 | Combined in-progress line |
| mem_resp_valid | output | 1 | Memory supplies the data |
| mem_resp_data | output | DATA_W | Memory reply word |
| done | output | 1 | Transaction complete strobe |
| done_shared | output | 1 | Combined copy-held bit returned with completion |

## Verification
A window controller stuck in its wrong state shows up at `done` immediately. Either the strobe comes early, while the in-progress line is still high, or it arrives after the count expected from the inhibit hold time or from `SNOOP_LAT`. A wrong latched command or snoop outcome shows up in the completion cycle as a wrong `mem_resp_valid` or `done_shared`. A wrong memory update cannot be seen until a later read of the same address returns the wrong word, so the stimulus re-reads addresses after write-backs, flushes, upgrades and requests that arrive while busy.

// File: rtl/snoop_pkg.sv
// Shared types for the snoop combiner and memory responder.
// Assumes a two-bit bus command field whose encoding is fixed by the bus.
package snoop_pkg;

    typedef enum logic [1:0] {
        CMD_RD  = 2'b00,
        CMD_RDX = 2'b01,
        CMD_UPG = 2'b10,
        CMD_WB  = 2'b11
    } bus_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_SNOOP = 2'b01,
        ST_DONE  = 2'b10
    } win_state_e;

    typedef struct packed {
        logic shared;
        logic dirty;
    } snoop_res_t;

endpackage

// File: rtl/snoop_wired_or.sv
// Models one open-collector bus line: it is asserted when any
// driver asserts it. Purely combinational, so it has no state.
module snoop_wired_or #(
    parameter int N_DRV = 4
) (
    input  logic [N_DRV-1:0] drv,
    output logic             line
);
    // Reduce every driver onto the single line.
    assign line = |drv;
endmodule

// File: rtl/snoop_window_ctrl.sv
// Sequences one bus transaction: idle, snoop window, completion cycle.
// Variable mode ends the window at the first edge with the in-progress
// line low; fixed mode ends it after SNOOP_LAT cycles.
// Assumes SNOOP_LAT >= 1.
module snoop_window_ctrl
    import snoop_pkg::*;
#(
    parameter bit FIXED_LAT = 1'b0,
    parameter int SNOOP_LAT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       inhibit_any,
    input  logic       shared_any,
    input  logic       dirty_any,
    output logic       accept,
    output logic       complete,
    output logic       busy,
    output logic       done,
    output snoop_res_t result
);
    localparam int CNT_W = $clog2(SNOOP_LAT + 1);

    win_state_e state_q;
    logic       cnt_hit;

    assign busy   = (state_q == ST_SNOOP);
    assign done   = (state_q == ST_DONE);
    assign accept = (state_q == ST_IDLE) && req_valid;

    generate
        if (FIXED_LAT) begin : g_fixed
            logic [CNT_W-1:0] cnt_q;
            // Count cycles spent in the snoop window.
            always_ff @(posedge clk) begin
                if (!rst_n || accept) cnt_q <= '0;
                else if (busy)        cnt_q <= cnt_q + 1'b1;
            end
            assign cnt_hit = (cnt_q == CNT_W'(SNOOP_LAT - 1));
        end else begin : g_variable
            assign cnt_hit = 1'b0;
        end
    endgenerate

    assign complete = busy && (FIXED_LAT ? cnt_hit : !inhibit_any);

    // Advance the transaction state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (req_valid) state_q <= ST_SNOOP;
                ST_SNOOP: if (complete)  state_q <= ST_DONE;
                default:                 state_q <= ST_IDLE;
            endcase
        end
    end

    // Freeze the combined snoop outcome at the end of the window.
    always_ff @(posedge clk) begin
        if (!rst_n)        result <= '0;
        else if (complete) result <= '{shared: shared_any, dirty: dirty_any};
    end
endmodule

// File: rtl/snoop_mem_regfile.sv
// Small main-memory model: one synchronous write port and one
// asynchronous read port. Every word clears to zero on reset.
module snoop_mem_regfile #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Clear on reset, otherwise store one word per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/snoop_mem_responder.sv
// Memory-side snoop combiner. It merges per-cache snoop outputs into
// three wired-OR lines, holds memory back until the snoop has ended,
// then either answers a read or defers to the owning cache and captures
// that cache's flushed data. Assumes one bus transaction at a time.
module snoop_mem_responder
    import snoop_pkg::*;
#(
    parameter int N_CACHE   = 4,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 16,
    parameter bit FIXED_LAT = 1'b0,
    parameter int SNOOP_LAT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_cmd,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [N_CACHE-1:0] snp_shared,
    input  logic [N_CACHE-1:0] snp_dirty,
    input  logic [N_CACHE-1:0] snp_inhibit,
    input  logic [DATA_W-1:0]  flush_data,
    output logic               sum_shared,
    output logic               sum_dirty,
    output logic               sum_inhibit,
    output logic               mem_resp_valid,
    output logic [DATA_W-1:0]  mem_resp_data,
    output logic               done,
    output logic               done_shared
);
    localparam int N_LINES = 3;

    logic [N_CACHE-1:0] line_drv [N_LINES];
    logic [N_LINES-1:0] line_out;

    assign line_drv[0] = snp_shared;
    assign line_drv[1] = snp_dirty;
    assign line_drv[2] = snp_inhibit;

    generate
        for (genvar g = 0; g < N_LINES; g++) begin : g_line
            snoop_wired_or #(.N_DRV(N_CACHE)) u_or (
                .drv  (line_drv[g]),
                .line (line_out[g])
            );
        end
    endgenerate

    assign sum_shared  = line_out[0];
    assign sum_dirty   = line_out[1];
    assign sum_inhibit = line_out[2];

    logic       win_accept;
    logic       win_complete;
    logic       win_busy;
    logic       win_done;
    snoop_res_t win_result;

    snoop_window_ctrl #(
        .FIXED_LAT (FIXED_LAT),
        .SNOOP_LAT (SNOOP_LAT)
    ) u_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .inhibit_any (sum_inhibit),
        .shared_any  (sum_shared),
        .dirty_any   (sum_dirty),
        .accept      (win_accept),
        .complete    (win_complete),
        .busy        (win_busy),
        .done        (win_done),
        .result      (win_result)
    );

    bus_cmd_e          cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    // Hold the accepted request for the whole transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= CMD_RD;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (win_accept) begin
            cmd_q   <= bus_cmd_e'(req_cmd);
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    logic              is_read;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;

    // Choose the memory update at window end: a write-back or a captured flush.
    always_comb begin
        is_read   = (cmd_q == CMD_RD) || (cmd_q == CMD_RDX);
        mem_we    = win_complete && ((cmd_q == CMD_WB) || (is_read && sum_dirty));
        mem_wdata = (cmd_q == CMD_WB) ? wdata_q : flush_data;
    end

    snoop_mem_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (addr_q),
        .wdata (mem_wdata),
        .raddr (addr_q),
        .rdata (mem_rdata)
    );

    // Drive the completion outputs from the frozen snoop outcome.
    always_comb begin
        done           = win_done;
        done_shared    = win_done && win_result.shared;
        mem_resp_valid = win_done && is_read && !win_result.dirty;
        mem_resp_data  = mem_resp_valid ? mem_rdata : '0;
    end
endmodule

// File: rtl/snoop_mem_responder_chk.sv
// Property checker for snoop_mem_responder, attached with bind.
// Looks only at ports plus the window-busy flag.
module snoop_mem_responder_chk #(
    parameter bit FIXED_LAT = 1'b0,
    parameter int SNOOP_LAT = 3
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic sum_inhibit,
    input logic busy,
    input logic done,
    input logic mem_resp_valid,
    input logic done_shared
);
    logic [15:0] win_len_q;

    // Measure how long the current snoop window has been open.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) win_len_q <= '0;
        else                 win_len_q <= win_len_q + 16'd1;
    end

    // R6: completion is a single-cycle strobe
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: returned shared bit only appears with completion
    a_r6_shared_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_shared |-> done);

    // R4: a memory reply only appears in the completion cycle
    a_r4_resp_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        mem_resp_valid |-> done);

    // R2: in variable mode an open window with the in-progress line high cannot finish
    a_r2_wait_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        (!FIXED_LAT && busy && sum_inhibit) |=> !done);

    // R3: in fixed mode the window is exactly SNOOP_LAT cycles long
    a_r3_fixed_len: assert property (@(posedge clk) disable iff (!rst_n)
        (FIXED_LAT && done) |-> (win_len_q == 16'(SNOOP_LAT)));

    // R9: a window only opens from an accepted request
    a_r9_open_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));
endmodule

bind snoop_mem_responder snoop_mem_responder_chk #(
    .FIXED_LAT (FIXED_LAT),
    .SNOOP_LAT (SNOOP_LAT)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .sum_inhibit    (sum_inhibit),
    .busy           (win_busy),
    .done           (done),
    .mem_resp_valid (mem_resp_valid),
    .done_shared    (done_shared)
);

// File: tb/snoop_mem_responder_bench.sv
// Bench: one variable-window and one fixed-window instance share stimulus.
module snoop_mem_responder_bench;
    localparam int NC = 4;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_cmd = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [NC-1:0] snp_shared = '0;
    logic [NC-1:0] snp_dirty = '0;
    logic [NC-1:0] snp_inhibit = '0;
    logic [DW-1:0] flush_data = '0;

    logic          v_sh, v_dt, v_inh, v_rv, v_done, v_dsh;
    logic [DW-1:0] v_rd;
    logic          f_sh, f_dt, f_inh, f_rv, f_done, f_dsh;
    logic [DW-1:0] f_rd;

    int total = 0;
    int bad = 0;
    logic [DW-1:0] model [1 << AW];

    always #10 clk = ~clk;

    snoop_mem_responder #(.N_CACHE(NC), .ADDR_W(AW), .DATA_W(DW),
                          .FIXED_LAT(1'b0), .SNOOP_LAT(LAT)) u_snoop_mem_responder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_wdata(req_wdata), .snp_shared(snp_shared),
        .snp_dirty(snp_dirty), .snp_inhibit(snp_inhibit), .flush_data(flush_data),
        .sum_shared(v_sh), .sum_dirty(v_dt), .sum_inhibit(v_inh),
        .mem_resp_valid(v_rv), .mem_resp_data(v_rd), .done(v_done), .done_shared(v_dsh));

    snoop_mem_responder #(.N_CACHE(NC), .ADDR_W(AW), .DATA_W(DW),
                          .FIXED_LAT(1'b1), .SNOOP_LAT(LAT)) u_snoop_mem_responder_fx (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_wdata(req_wdata), .snp_shared(snp_shared),
        .snp_dirty(snp_dirty), .snp_inhibit(snp_inhibit), .flush_data(flush_data),
        .sum_shared(f_sh), .sum_dirty(f_dt), .sum_inhibit(f_inh),
        .mem_resp_valid(f_rv), .mem_resp_data(f_rd), .done(f_done), .done_shared(f_dsh));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_resp(input logic [1:0] cmd, input logic dirty);
        return (cmd == 2'b00 || cmd == 2'b01) && !dirty;
    endfunction

    // One transaction: k = edges the in-progress line stays high after the accept edge.
    task automatic run_txn(input logic [1:0] cmd, input logic [AW-1:0] addr,
                           input logic [DW-1:0] wd, input logic [NC-1:0] shv,
                           input logic [NC-1:0] dtv, input logic [NC-1:0] inh,
                           input int k, input logic [DW-1:0] fl, input bit spurious);
        int vd = -1;
        int fd = -1;
        int vcnt = 0;
        int fcnt = 0;
        logic ex_sh = |shv;
        logic ex_dt = |dtv;
        logic ex_rv = exp_resp(cmd, ex_dt);
        logic [DW-1:0] ex_rd = ex_rv ? model[addr] : '0;
        @(negedge clk);
        req_valid = 1'b1; req_cmd = cmd; req_addr = addr; req_wdata = wd;
        snp_shared = shv; snp_dirty = dtv; flush_data = fl;
        snp_inhibit = (k > 0) ? inh : '0;
        for (int e = 1; e < 40; e++) begin
            @(negedge clk);
            if (e == 1) begin
                chk("R1 shared", v_sh, |snp_shared);
                chk("R1 dirty", v_dt, |snp_dirty);
                chk("R1 inhibit", v_inh, |snp_inhibit);
                if (spurious) begin
                    req_cmd = 2'b11; req_addr = addr ^ 4'h1; req_wdata = 16'hDEAD;
                end else begin
                    req_valid = 1'b0;
                end
            end else begin
                req_valid = 1'b0;
                req_cmd = cmd; req_addr = addr; req_wdata = wd;
            end
            if (v_done) begin
                vcnt++; vd = e;
                chk("R4 var resp_valid", v_rv, ex_rv);
                chk("R4 var resp_data", v_rd, ex_rd);
                chk("R6 var done_shared", v_dsh, ex_sh);
            end
            if (f_done) begin
                fcnt++; fd = e;
                chk("R4 fix resp_valid", f_rv, ex_rv);
                chk("R4 fix resp_data", f_rd, ex_rd);
                chk("R6 fix done_shared", f_dsh, ex_sh);
            end
            if (e == k + 1) snp_inhibit = '0;
            if (vd > 0 && fd > 0 && e > vd && e > fd) break;
        end
        chk("R2 variable latency", vd, k + 2);
        chk("R3 fixed latency", fd, LAT + 1);
        chk("R6 var one pulse", vcnt, 1);
        chk("R6 fix one pulse", fcnt, 1);
        if (cmd == 2'b11) model[addr] = wd;
        else if (cmd != 2'b10 && ex_dt) model[addr] = fl;
        snp_shared = '0; snp_dirty = '0; snp_inhibit = '0;
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) model[i] = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 var done idle", v_done, 1'b0);
        chk("R10 var resp idle", v_rv, 1'b0);
        chk("R10 fix done idle", f_done, 1'b0);
        chk("R10 fix resp idle", f_rv, 1'b0);
        // R10: reset memory reads back as zero
        run_txn(2'b00, 4'h5, '0, 4'b0000, 4'b0000, 4'b0000, 0, 16'h0, 1'b0);
        // R7: write-back, then R4 read-back
        run_txn(2'b11, 4'h3, 16'h1234, 4'b0000, 4'b0000, 4'b0010, 2, 16'h0, 1'b0);
        run_txn(2'b00, 4'h3, '0, 4'b0100, 4'b0000, 4'b1000, 1, 16'h0, 1'b0);
        // R5: owning cache flushes, memory silent, then read back
        run_txn(2'b01, 4'h3, '0, 4'b0001, 4'b0001, 4'b0001, 3, 16'hBEEF, 1'b0);
        run_txn(2'b00, 4'h3, '0, 4'b0000, 4'b0000, 4'b0000, 0, 16'h0, 1'b0);
        // R8: upgrade leaves memory untouched even with a flush value present
        run_txn(2'b10, 4'h3, 16'h7777, 4'b1111, 4'b0000, 4'b0000, 0, 16'h5555, 1'b0);
        run_txn(2'b00, 4'h3, '0, 4'b0000, 4'b0000, 4'b0000, 0, 16'h0, 1'b0);
        // R9: request held during the window is ignored; R3: long inhibit ignored in fixed mode
        run_txn(2'b00, 4'h6, '0, 4'b0000, 4'b0000, 4'b1100, 5, 16'h0, 1'b1);
        run_txn(2'b00, 4'h7, '0, 4'b0000, 4'b0000, 4'b0000, 0, 16'h0, 1'b0);
        chk("R9 no spurious write", model[7], 16'h0);
        for (int n = 0; n < 80; n++) begin
            logic [1:0]    c  = 2'($urandom % 4);
            logic [AW-1:0] a  = AW'($urandom % 16);
            logic [NC-1:0] dv = (($urandom % 3) == 0) ? NC'(1 << ($urandom % NC)) : '0;
            run_txn(c, a, DW'($urandom), NC'($urandom), dv, NC'(($urandom % 15) + 1),
                    int'($urandom % 6), DW'($urandom), ($urandom % 4) == 0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    int wd_cycles = 0;
    always @(posedge clk) begin
        wd_cycles++;
        if (wd_cycles > 150000) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule